// File: doc/BRIEF.md
# Eight-Line Interrupt Controller Command Decoder

This block is the byte-wide register front end of an eight-line interrupt controller. Software talks to it through two addresses. Address 0 takes initialisation and operation commands. Address 1 takes the follow-on initialisation bytes and, in normal operation, the mask. The block holds the mask, the in-service set, the rotating priority offset, the vector base and the mode bits. From these and the pending lines it decides whether to raise a request to the processor.

Pending lines come from an external request latch. The block drives a one-hot clear back to that latch whenever a line is acknowledged or polled. On an acknowledge strobe it returns the vector for the winning line and records that line as in service. Register reads return the pending lines, the in-service set, the mask or a poll result.

Top module: `pic_cmd_decoder`

## Requirements
- R1: After reset the mask, the in-service set and the priority offset are zero, `int_req` is low, and line 0 has the highest priority.
- R2: A write to address 0 with bit 4 set restarts the controller. It clears the mask, the in-service set, the offset, the base and all mode bits. It forces `int_req` low on the next cycle, records bit 0 as "fourth byte expected", and waits for the first address-1 byte.
- R3: During initialisation the first address-1 byte sets the vector base to its bits 7:3. The second byte finishes initialisation unless a fourth byte was expected. A fourth byte sets special nesting from bit 4 and auto end-of-interrupt from bit 1.
- R4: An address-1 write outside initialisation loads the mask. A line whose mask bit is 1 never raises `int_req` and is never acknowledged.
- R5: An address-0 write with bit 4 clear and bit 3 set is an operation command:
  - Bit 2 arms poll mode.
  - When bit 1 is set, bit 0 chooses which set a non-poll address-0 read returns: 1 for the in-service set, 0 for the pending lines.
  - When bit 6 is set, bit 5 sets or clears special mask mode. In that mode, lines in service neither block other lines nor request again.
- R6: Priority position p maps to line (p + offset) mod 8, and position 0 is the highest. `int_req` goes high when the best unmasked pending line has a strictly higher priority than the best in-service line. It follows each state change one clock later.
- R7: During `inta`, `vector` equals base×8 plus the winning line. At the clock edge the line's in-service bit is set and `pend_clr` pulses that line's bit alone.
- R8: With bits 4 and 3 clear, bits 7:5 form a command:
  - Value 1 clears the highest-priority in-service bit.
  - Value 5 does the same and then rotates.
  - Value 2 changes nothing.
- R9: Further command values:
  - Value 3 clears the in-service bit of the line given in bits 2:0.
  - Value 7 clears that bit and rotates.
  - Value 6 sets the offset to (bits 2:0 + 1) mod 8.
  - A rotation on line L sets the offset to (L + 1) mod 8, so L becomes the lowest priority.
- R10: With auto end-of-interrupt on, an acknowledge leaves the in-service set unchanged. If rotate-on-auto-EOI is on (command value 4 sets it, value 0 clears it), the acknowledge also rotates on the acknowledged line.
- R11: An acknowledge or poll with no line allowed to win reports line 7, giving vector base×8+7. It changes no state.
- R12: With poll mode armed, a read at either address returns the winning line number (or 7 if none). The read clears that line's pending and in-service bits and disarms poll mode. Later reads return the registers again.
- R13: With special nesting on, an in-service bit on the cascade line (line 2) does not block requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | Register address (0 = command, 1 = data) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high, zero otherwise |
| pend | input | 8 | Pending lines from the external request latch |
| pend_clr | output | 8 | One-hot clear to the request latch on acknowledge or poll |
| inta | input | 1 | Interrupt acknowledge strobe |
| vector | output | 8 | Vector number for the current acknowledge |
| int_req | output | 1 | Interrupt request to the processor |

## Verification
The bench targets the priority rotation edges: rotation by command value 6, the rotating non-specific and specific EOIs, and rotation on auto-EOI. A design that computes the offset as L instead of L+1 acknowledges the wrong line of a pair and returns a wrong vector. It also checks that an in-service line blocks lower lines but not higher ones, and that special mask and special nesting lift that block. A decoder that mixes up these modes leaves `int_req` low where it must rise. Poll reads are checked for clearing the pending bit and leaving poll mode after one read. Initialisation without a fourth byte is checked to return to mask loading, since a decoder that always waits for the fourth byte would swallow the next mask write.

// File: rtl/pic_cmd_decoder.sv
module pic_cmd_decoder #(
  parameter int CASC_LINE = 2,
  parameter int SPUR_LINE = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] pend,
  output logic [7:0] pend_clr,
  input  logic       inta,
  output logic [7:0] vector,
  output logic       int_req
);

  localparam int NL = 8;
  localparam int LW = $clog2(NL);
  localparam logic [NL-1:0] CASC_BIT = NL'(1) << CASC_LINE;
  localparam logic [LW-1:0] SPUR = LW'(SPUR_LINE);

  logic [NL-1:0] imr_q, isr_q;
  logic [LW-1:0] off_q;
  logic [7:LW]   base_q;
  logic [1:0]    step_q;
  logic          w4_q, aeoi_q, raeoi_q, sfnm_q, smm_q, rsel_q, poll_q, int_req_q;

  function automatic logic [LW:0] top_prio(input logic [NL-1:0] m, input logic [LW-1:0] off);
    logic [LW:0] r;
    r = (LW+1)'(NL);
    for (int p = NL-1; p >= 0; p--)
      if (m[LW'(p) + off]) r = (LW+1)'(p);
    return r;
  endfunction

  logic [NL-1:0] req_m, isr_m, win_oh;
  logic [LW:0]   req_p, cur_p, isr_p;
  logic [LW-1:0] win_line, rep_line, eoi_line;
  logic          win_valid, eoi_any;

  assign req_m     = pend & ~imr_q & (smm_q ? ~isr_q : '1);
  assign isr_m     = smm_q ? '0 : (sfnm_q ? (isr_q & ~CASC_BIT) : isr_q);
  assign req_p     = top_prio(req_m, off_q);
  assign cur_p     = top_prio(isr_m, off_q);
  assign win_valid = req_p < cur_p;
  assign win_line  = req_p[LW-1:0] + off_q;
  assign rep_line  = win_valid ? win_line : SPUR;
  assign win_oh    = win_valid ? (NL'(1) << win_line) : '0;
  assign isr_p     = top_prio(isr_q, off_q);
  assign eoi_any   = !isr_p[LW];
  assign eoi_line  = isr_p[LW-1:0] + off_q;

  logic wr_cmd, init_w, ocw3_w, ocw2_w, data_w, ack_go, poll_go;
  assign wr_cmd  = wr_en && !addr;
  assign init_w  = wr_cmd && wdata[4];
  assign ocw3_w  = wr_cmd && !wdata[4] && wdata[3];
  assign ocw2_w  = wr_cmd && !wdata[4] && !wdata[3];
  assign data_w  = wr_en && addr;
  assign ack_go  = inta && !wr_en;
  assign poll_go = rd_en && poll_q && !wr_en && !inta;

  assign pend_clr = (ack_go || poll_go) ? win_oh : '0;
  assign vector   = {base_q, rep_line};
  assign int_req  = int_req_q;
  assign rdata    = !rd_en ? '0 :
                    poll_q ? {{(8-LW){1'b0}}, rep_line} :
                    addr   ? imr_q :
                    rsel_q ? isr_q : pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imr_q <= '0; isr_q <= '0; off_q <= '0; base_q <= '0; step_q <= '0;
      w4_q <= 1'b0; aeoi_q <= 1'b0; raeoi_q <= 1'b0; sfnm_q <= 1'b0;
      smm_q <= 1'b0; rsel_q <= 1'b0; poll_q <= 1'b0; int_req_q <= 1'b0;
    end else begin
      int_req_q <= win_valid;
      if (init_w) begin
        imr_q <= '0; isr_q <= '0; off_q <= '0; base_q <= '0;
        aeoi_q <= 1'b0; raeoi_q <= 1'b0; sfnm_q <= 1'b0;
        smm_q <= 1'b0; rsel_q <= 1'b0; poll_q <= 1'b0;
        int_req_q <= 1'b0;
        step_q <= 2'd1;
        w4_q <= wdata[0];
      end else if (data_w) begin
        case (step_q)
          2'd0: imr_q <= wdata;
          2'd1: begin base_q <= wdata[7:LW]; step_q <= 2'd2; end
          2'd2: step_q <= w4_q ? 2'd3 : 2'd0;
          default: begin
            sfnm_q <= wdata[4];
            aeoi_q <= wdata[1];
            step_q <= 2'd0;
          end
        endcase
      end else if (ocw3_w) begin
        if (wdata[2]) poll_q <= 1'b1;
        if (wdata[1]) rsel_q <= wdata[0];
        if (wdata[6]) smm_q <= wdata[5];
      end else if (ocw2_w) begin
        case (wdata[7:5])
          3'd0: raeoi_q <= 1'b0;
          3'd4: raeoi_q <= 1'b1;
          3'd1: if (eoi_any) isr_q[eoi_line] <= 1'b0;
          3'd5: if (eoi_any) begin
            isr_q[eoi_line] <= 1'b0;
            off_q <= eoi_line + LW'(1);
          end
          3'd3: isr_q[wdata[LW-1:0]] <= 1'b0;
          3'd6: off_q <= wdata[LW-1:0] + LW'(1);
          3'd7: begin
            isr_q[wdata[LW-1:0]] <= 1'b0;
            off_q <= wdata[LW-1:0] + LW'(1);
          end
          default: ;
        endcase
      end else if (ack_go) begin
        if (win_valid) begin
          if (aeoi_q) begin
            if (raeoi_q) off_q <= win_line + LW'(1);
          end else begin
            isr_q[win_line] <= 1'b1;
          end
        end
      end else if (poll_go) begin
        if (win_valid) isr_q[win_line] <= 1'b0;
        poll_q <= 1'b0;
      end
    end
  end

  // R2
  init_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_w |=> (!int_req && step_q == 2'd1));

  // R6
  req_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_w |=> (int_req == $past(win_valid)));

  // R7
  clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pend_clr));

  // R7
  ack_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_go && win_valid && !aeoi_q) |=> isr_q[$past(win_line)]);

  // R10
  aeoi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_go && aeoi_q) |=> $stable(isr_q));

  // R12
  poll_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_go |=> !poll_q);

  // R11
  spur_nochg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_go && !win_valid) |=> ($stable(isr_q) && $stable(off_q)));

endmodule

// File: tb/pic_cmd_decoder_bench.sv
`timescale 1ns/1ps
module pic_cmd_decoder_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, inta = 1'b0;
  logic [7:0] wdata = '0, rdata, pend, pend_clr, vector, set_req = '0;
  logic int_req;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pic_cmd_decoder u_pic_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pend(pend), .pend_clr(pend_clr),
    .inta(inta), .vector(vector), .int_req(int_req));

  always @(posedge clk)
    if (!rst_n) pend <= '0;
    else pend <= (pend & ~pend_clr) | set_req;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic do_wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic a, output logic [7:0] v);
    rd_en = 1'b1; addr = a;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_ack(output logic [7:0] v);
    inta = 1'b1;
    #1 v = vector;
    @(negedge clk);
    inta = 1'b0;
  endtask

  task automatic raise(input logic [7:0] m);
    set_req = m;
    @(negedge clk);
    set_req = '0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic setup(input logic [7:0] base, input bit w4, input logic [7:0] w4val);
    do_wr(1'b0, w4 ? 8'h11 : 8'h10);
    do_wr(1'b1, base);
    do_wr(1'b1, 8'h00);
    if (w4) do_wr(1'b1, w4val);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 int_req", {7'd0, int_req}, 8'h00);
    do_rd(1'b1, v); chk("R1 mask", v, 8'h00);
    do_wr(1'b0, 8'h0B); do_rd(1'b0, v); chk("R1 isr", v, 8'h00);
  endtask

  task automatic t_nested();
    logic [7:0] v;
    setup(8'h45, 1'b0, 8'h00);
    raise(8'h08); settle();
    chk("R6 req line3", {7'd0, int_req}, 8'h01);
    do_ack(v); chk("R3 R7 vector", v, 8'h43);
    do_wr(1'b0, 8'h0B); do_rd(1'b0, v); chk("R7 isr set", v, 8'h08);
    raise(8'h20); settle();
    chk("R6 lower blocked", {7'd0, int_req}, 8'h00);
    raise(8'h02); settle();
    chk("R6 higher passes", {7'd0, int_req}, 8'h01);
    do_ack(v); chk("R7 vector line1", v, 8'h41);
    do_wr(1'b0, 8'h20); do_rd(1'b0, v); chk("R8 ns eoi", v, 8'h08);
    do_wr(1'b0, 8'h63); do_rd(1'b0, v); chk("R9 spec eoi", v, 8'h00);
    settle(); do_ack(v); chk("R6 line5 after eoi", v, 8'h45);
    do_wr(1'b0, 8'h20);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    setup(8'h40, 1'b0, 8'h00);
    do_wr(1'b1, 8'h20);
    raise(8'h20); settle();
    chk("R4 masked no req", {7'd0, int_req}, 8'h00);
    do_rd(1'b1, v); chk("R4 mask read", v, 8'h20);
    do_wr(1'b0, 8'h0A); do_rd(1'b0, v); chk("R5 pend read", v, 8'h20);
    do_wr(1'b1, 8'h00); settle();
    chk("R4 unmask req", {7'd0, int_req}, 8'h01);
    do_ack(v); chk("R4 vector", v, 8'h45);
    do_wr(1'b0, 8'h20);
  endtask

  task automatic t_spur();
    logic [7:0] v;
    setup(8'h40, 1'b0, 8'h00);
    do_ack(v); chk("R11 none", v, 8'h47);
    do_wr(1'b0, 8'h0B); do_rd(1'b0, v); chk("R11 isr kept", v, 8'h00);
    raise(8'h01); settle(); do_ack(v); chk("R11 line0", v, 8'h40);
    raise(8'h02); settle(); do_ack(v); chk("R11 blocked", v, 8'h47);
    do_wr(1'b0, 8'h0A); do_rd(1'b0, v); chk("R11 pend kept", v, 8'h02);
    do_wr(1'b0, 8'h20); settle(); do_ack(v); chk("R11 after eoi", v, 8'h41);
    do_wr(1'b0, 8'h20);
  endtask

  task automatic t_rotate();
    logic [7:0] v;
    setup(8'h40, 1'b0, 8'h00);
    do_wr(1'b0, 8'hC3);
    raise(8'h44); settle();
    do_ack(v); chk("R9 set prio", v, 8'h46);
    settle(); chk("R9 line2 blocked", {7'd0, int_req}, 8'h00);
    do_wr(1'b0, 8'h40);
    do_wr(1'b0, 8'h0B); do_rd(1'b0, v); chk("R8 cmd2 nop", v, 8'h40);
    do_wr(1'b0, 8'hA0); settle();
    do_ack(v); chk("R8 rot eoi", v, 8'h42);
    do_wr(1'b0, 8'hE2);
    raise(8'h18); settle();
    do_ack(v); chk("R9 spec rot", v, 8'h43);
    do_wr(1'b0, 8'h20); settle();
    do_ack(v); chk("R9 next", v, 8'h44);
    do_wr(1'b0, 8'h20);
    do_rd(1'b0, v); chk("R9 isr empty", v, 8'h00);
  endtask

  task automatic t_aeoi();
    logic [7:0] v;
    setup(8'h48, 1'b1, 8'h02);
    do_rd(1'b1, v); chk("R2 mask cleared", v, 8'h00);
    do_wr(1'b0, 8'h80);
    raise(8'h03); settle();
    do_ack(v); chk("R10 first", v, 8'h48);
    do_wr(1'b0, 8'h0B); do_rd(1'b0, v); chk("R10 isr clear", v, 8'h00);
    do_ack(v); chk("R10 rot1", v, 8'h49);
    raise(8'h05); settle();
    do_ack(v); chk("R10 rot2", v, 8'h4A);
    do_ack(v); chk("R10 rot3", v, 8'h48);
    do_wr(1'b0, 8'h00);
    raise(8'h06); settle();
    do_ack(v); chk("R10 norot a", v, 8'h49);
    do_ack(v); chk("R10 norot b", v, 8'h4A);
    raise(8'h03); settle();
    do_ack(v); chk("R10 norot c", v, 8'h49);
    do_ack(v);
  endtask

  task automatic t_poll();
    logic [7:0] v;
    setup(8'h40, 1'b0, 8'h00);
    do_wr(1'b1, 8'h81);
    raise(8'h10); settle();
    do_wr(1'b0, 8'h0C); do_rd(1'b1, v); chk("R12 poll line", v, 8'h04);
    do_wr(1'b0, 8'h0A); do_rd(1'b0, v); chk("R12 pend cleared", v, 8'h00);
    do_wr(1'b0, 8'h0B); do_rd(1'b0, v); chk("R12 isr cleared", v, 8'h00);
    do_wr(1'b0, 8'h0C); do_rd(1'b0, v); chk("R12 poll none", v, 8'h07);
    do_rd(1'b1, v); chk("R12 poll off", v, 8'h81);
  endtask

  task automatic t_reinit();
    logic [7:0] v;
    setup(8'h40, 1'b0, 8'h00);
    raise(8'h04); settle();
    chk("R2 pre req", {7'd0, int_req}, 8'h01);
    do_wr(1'b0, 8'h10);
    chk("R2 drop", {7'd0, int_req}, 8'h00);
    do_wr(1'b1, 8'h57);
    do_wr(1'b1, 8'h00);
    do_wr(1'b1, 8'hFF); settle();
    chk("R3 no fourth", {7'd0, int_req}, 8'h00);
    do_rd(1'b1, v); chk("R3 mask loaded", v, 8'hFF);
    do_wr(1'b1, 8'h00); settle();
    do_ack(v); chk("R3 base", v, 8'h52);
    do_wr(1'b0, 8'h20);
  endtask

  task automatic t_smask();
    logic [7:0] v;
    setup(8'h40, 1'b0, 8'h00);
    raise(8'h08); settle(); do_ack(v); chk("R5 line3", v, 8'h43);
    raise(8'h20); settle();
    chk("R5 blocked", {7'd0, int_req}, 8'h00);
    do_wr(1'b0, 8'h68); settle();
    chk("R5 smask req", {7'd0, int_req}, 8'h01);
    do_ack(v); chk("R5 smask vec", v, 8'h45);
    do_wr(1'b0, 8'h48);
    do_wr(1'b0, 8'h63); do_wr(1'b0, 8'h65);
    do_wr(1'b0, 8'h0B); do_rd(1'b0, v); chk("R5 isr empty", v, 8'h00);
  endtask

  task automatic t_sfnm();
    logic [7:0] v;
    setup(8'h40, 1'b1, 8'h10);
    raise(8'h04); settle(); do_ack(v); chk("R13 first", v, 8'h42);
    raise(8'h04); settle();
    chk("R13 casc repeat", {7'd0, int_req}, 8'h01);
    do_ack(v); chk("R13 vec", v, 8'h42);
    do_wr(1'b0, 8'h62);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nested();
    t_mask();
    t_spur();
    t_rotate();
    t_aeoi();
    t_poll();
    t_reinit();
    t_smask();
    t_sfnm();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule